// File: doc/BRIEF.md
# Power-up and Oscillator Start-up Reset Sequencer

This block gathers the reset causes of a chip (power-on, the external reset pin, the watchdog and wake from sleep) and turns any of them into one held device reset. Once every cause has gone away, the block runs two delays in a fixed order. The first is an optional power-up delay, counted on clock-enable ticks from a slow internal RC oscillator. The second is an optional oscillator start-up delay, counted on ticks that mark main-oscillator cycles. When both are done, the block releases the reset.

The external pin passes through a glitch filter. It can also be given over to general input use, and then the reset logic ignores its level. The power-up delay has an active-low configuration enable. The oscillator delay applies only when two things hold: the oscillator runs in one of the crystal or resonator modes, and the latest reset cause was power-on or wake. Any new cause that arrives while a sequence runs sends the sequence back to its start. A phase output shows where the sequence stands. A pin-drive output shows when the block would pull the external pin low. That output stays inactive for watchdog and wake causes.

Top module: `rst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `phase_o` is 0 (idle) and `dev_rst_o` is 1. The register reset is recorded as a power-on cause.
- R2: With the pin in reset mode, a low level on `pin_n_i` becomes a reset event only on the FILT_LEN-th consecutive low clock cycle, and on every further low cycle. A shorter low pulse leaves all outputs unchanged.
- R3: When `cfg_pin_rst_en_i` is 0, the level on `pin_n_i` has no effect on the sequence, and `pin_drive_o` is 0.
- R4: In the cycle after any event (power-on, accepted pin, watchdog or wake) `phase_o` is idle (0) and `dev_rst_o` is 1. This holds in any phase. The sequence stays idle while events continue.
- R5: From idle, in a cycle with no event, the sequence goes to the power-up phase (1) when `cfg_pwrt_en_n_i` is 0. Otherwise it goes straight to the step R7 or R8 chooses.
- R6: The power-up phase lasts until PWRT_TICKS `rc_tick_i` pulses have been seen in it. The phase changes in the cycle after the last of those pulses.
- R7: The oscillator phase (2) is entered only when two conditions hold: the most recent event cycle included power-on or wake, and `osc_mode_i` is 0, 1 or 2 (the crystal and resonator modes). In that phase the sequence stays until OST_CYCLES `osc_tick_i` pulses have been seen, and leaves in the cycle after the last one.
- R8: When the oscillator phase does not apply, the sequence goes to run (3). `dev_rst_o` is 0 only in run, and run persists until the next event.
- R9: `pin_drive_o` is 1 only while `dev_rst_o` is 1, the pin is in reset mode, and the most recent event cycle included power-on or an accepted pin low. A watchdog or wake cause on its own leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous register reset, active low; counts as a power-on cause |
| cfg_pin_rst_en_i | input | 1 | 1: the pin is the reset input; 0: the pin is a general input |
| cfg_pwrt_en_n_i | input | 1 | Power-up delay enable, active low |
| osc_mode_i | input | 3 | Oscillator mode; 0, 1 and 2 are the crystal and resonator modes |
| pin_n_i | input | 1 | External reset pin level, active low, synchronous to clk |
| por_evt_i | input | 1 | Power-on detection strobe |
| wdt_evt_i | input | 1 | Watchdog expiry strobe |
| wake_evt_i | input | 1 | Wake-from-sleep strobe |
| rc_tick_i | input | 1 | Clock enable from the internal RC oscillator |
| osc_tick_i | input | 1 | Clock enable, one per main-oscillator cycle |
| dev_rst_o | output | 1 | Device reset, held high until run |
| pin_drive_o | output | 1 | Request to pull the external pin low |
| phase_o | output | 2 | 0 idle, 1 power-up, 2 oscillator start-up, 3 run |

## Verification
The bench sends pin pulses exactly one cycle shorter than the filter length and exactly equal to it. A filter off by one would either let a glitch reset the chip or need an extra low cycle. It stops sequences with watchdog and wake events in the middle of the power-up and oscillator phases. A design that resumed its counters instead of restarting would release the reset too early. It tries each cause against crystal and non-crystal modes, with the power-up delay both on and off. A design that ran the oscillator delay after a watchdog cause, or skipped it after wake, would stay in reset too long or too short. It also checks that the pin-drive output stays quiet for watchdog causes and whenever the pin is a general input.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PWRT = 2'd1,
    PH_OST  = 2'd2,
    PH_RUN  = 2'd3
  } phase_e;

  localparam int OSC_MODE_W = 3;

  // Crystal and resonator modes occupy codes 0..2
  function automatic logic osc_is_crystal(input logic [OSC_MODE_W-1:0] mode);
    return (mode <= OSC_MODE_W'(2));
  endfunction

  // Step taken once the power-up delay is done or skipped
  function automatic phase_e after_pwrt(input logic ost_req,
                                        input logic [OSC_MODE_W-1:0] mode);
    return (ost_req && osc_is_crystal(mode)) ? PH_OST : PH_RUN;
  endfunction

  // Step taken when the idle phase sees no event
  function automatic phase_e after_idle(input logic pwrt_en_n,
                                        input logic ost_req,
                                        input logic [OSC_MODE_W-1:0] mode);
    return (!pwrt_en_n) ? PH_PWRT : after_pwrt(ost_req, mode);
  endfunction

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_mode_i,
  input  logic pin_n_i,
  output logic accept_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] low_cnt;
  logic          low_now;

  assign low_now  = pin_mode_i && !pin_n_i;
  assign accept_o = low_now && (low_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!low_now) begin
      low_cnt <= '0;
    end else if (low_cnt != LAST) begin
      low_cnt <= low_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rst_tick_counter.sv
module rst_tick_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign done_o = run_i && tick_i && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run_i || done_o) begin
      cnt <= '0;
    end else if (tick_i) begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  por_i,
  input  logic                  pin_i,
  input  logic                  wdt_i,
  input  logic                  wake_i,
  input  logic                  pwrt_en_n_i,
  input  logic [OSC_MODE_W-1:0] osc_mode_i,
  input  logic                  pwrt_done_i,
  input  logic                  ost_done_i,
  output phase_e                phase_o,
  output logic                  drive_cause_o,
  output logic                  any_evt_o
);
  phase_e phase_q, phase_d;
  logic   ost_req_q, ost_req_d;
  logic   drv_q, drv_d;

  assign any_evt_o = por_i || pin_i || wdt_i || wake_i;

  always_comb begin
    phase_d   = phase_q;
    ost_req_d = ost_req_q;
    drv_d     = drv_q;
    if (any_evt_o) begin
      phase_d   = PH_IDLE;
      ost_req_d = por_i || wake_i;
      drv_d     = por_i || pin_i;
    end else begin
      unique case (phase_q)
        PH_IDLE: phase_d = after_idle(pwrt_en_n_i, ost_req_q, osc_mode_i);
        PH_PWRT: if (pwrt_done_i) phase_d = after_pwrt(ost_req_q, osc_mode_i);
        PH_OST:  if (ost_done_i)  phase_d = PH_RUN;
        PH_RUN:  phase_d = PH_RUN;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      ost_req_q <= 1'b1;
      drv_q     <= 1'b1;
    end else begin
      phase_q   <= phase_d;
      ost_req_q <= ost_req_d;
      drv_q     <= drv_d;
    end
  end

  assign phase_o       = phase_q;
  assign drive_cause_o = drv_q;
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int FILT_LEN   = 4,
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_pin_rst_en_i,
  input  logic       cfg_pwrt_en_n_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pin_n_i,
  input  logic       por_evt_i,
  input  logic       wdt_evt_i,
  input  logic       wake_evt_i,
  input  logic       rc_tick_i,
  input  logic       osc_tick_i,
  output logic       dev_rst_o,
  output logic       pin_drive_o,
  output logic [1:0] phase_o
);
  logic   filt_acc;
  logic   any_evt;
  logic   pwrt_done;
  logic   ost_done;
  logic   drive_cause;
  phase_e phase;

  rst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_mode_i (cfg_pin_rst_en_i),
    .pin_n_i    (pin_n_i),
    .accept_o   (filt_acc)
  );

  rst_tick_counter #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (phase == PH_PWRT),
    .tick_i (rc_tick_i),
    .done_o (pwrt_done)
  );

  rst_tick_counter #(.LIMIT(OST_CYCLES)) u_ost_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (phase == PH_OST),
    .tick_i (osc_tick_i),
    .done_o (ost_done)
  );

  rst_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_i         (por_evt_i),
    .pin_i         (filt_acc),
    .wdt_i         (wdt_evt_i),
    .wake_i        (wake_evt_i),
    .pwrt_en_n_i   (cfg_pwrt_en_n_i),
    .osc_mode_i    (osc_mode_i),
    .pwrt_done_i   (pwrt_done),
    .ost_done_i    (ost_done),
    .phase_o       (phase),
    .drive_cause_o (drive_cause),
    .any_evt_o     (any_evt)
  );

  assign phase_o     = phase;
  assign dev_rst_o   = (phase != PH_RUN);
  assign pin_drive_o = dev_rst_o && cfg_pin_rst_en_i && drive_cause;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_pin_rst_en_i,
  input logic       cfg_pwrt_en_n_i,
  input logic [2:0] osc_mode_i,
  input logic       por_evt_i,
  input logic       wdt_evt_i,
  input logic       wake_evt_i,
  input logic       rc_tick_i,
  input logic       osc_tick_i,
  input logic       dev_rst_o,
  input logic       pin_drive_o,
  input logic [1:0] phase_o,
  input logic       filt_acc,
  input logic       any_evt
);
  AST_NO_ACCEPT_WHEN_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pin_rst_en_i |-> !filt_acc); // R3

  AST_EVENT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> (phase_o == 2'd0) && dev_rst_o); // R4

  AST_IDLE_TO_PWRT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && !any_evt && !cfg_pwrt_en_n_i) |=> phase_o == 2'd1); // R5

  AST_PWRT_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1 && !any_evt && !rc_tick_i) |=> phase_o == 2'd1); // R6

  AST_OST_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2 && !any_evt && !osc_tick_i) |=> phase_o == 2'd2); // R7

  AST_NO_OST_OFF_CRYSTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0 && !any_evt && cfg_pwrt_en_n_i && osc_mode_i > 3'd2)
      |=> phase_o == 2'd3); // R8

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd3 && !any_evt) |=> (phase_o == 2'd3) && !dev_rst_o); // R8

  AST_WDT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_evt_i && !por_evt_i && !filt_acc) |=> !pin_drive_o); // R9

  AST_DRIVE_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive_o |-> dev_rst_o && cfg_pin_rst_en_i); // R9
endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_pin_rst_en_i (cfg_pin_rst_en_i),
  .cfg_pwrt_en_n_i  (cfg_pwrt_en_n_i),
  .osc_mode_i       (osc_mode_i),
  .por_evt_i        (por_evt_i),
  .wdt_evt_i        (wdt_evt_i),
  .wake_evt_i       (wake_evt_i),
  .rc_tick_i        (rc_tick_i),
  .osc_tick_i       (osc_tick_i),
  .dev_rst_o        (dev_rst_o),
  .pin_drive_o      (pin_drive_o),
  .phase_o          (phase_o),
  .filt_acc         (filt_acc),
  .any_evt          (any_evt)
);

// File: tb/rst_seq_tb.sv
`timescale 1ns/1ps
module rst_seq_tb;
  localparam int FL = 4;
  localparam int PW = 5;
  localparam int OC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_en = 1'b1, pwrt_n = 1'b0;
  logic [2:0] mode = 3'd1;
  logic pin_n = 1'b1, por = 1'b0, wdt = 1'b0, wake = 1'b0;
  logic rc_tick = 1'b0, osc_tick = 1'b0;
  logic dev_rst, pin_drive;
  logic [1:0] phase;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  rst_seq #(.FILT_LEN(FL), .PWRT_TICKS(PW), .OST_CYCLES(OC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pin_rst_en_i(pin_en), .cfg_pwrt_en_n_i(pwrt_n),
    .osc_mode_i(mode), .pin_n_i(pin_n), .por_evt_i(por), .wdt_evt_i(wdt),
    .wake_evt_i(wake), .rc_tick_i(rc_tick), .osc_tick_i(osc_tick),
    .dev_rst_o(dev_rst), .pin_drive_o(pin_drive), .phase_o(phase));

  // tick generators: RC tick every 3rd cycle, oscillator tick every 2nd
  int rc_div = 0, osc_div = 0;
  always @(negedge clk) begin
    rc_div  = (rc_div + 1) % 3;
    osc_div = (osc_div + 1) % 2;
    rc_tick  <= (rc_div == 0);
    osc_tick <= (osc_div == 0);
  end

  // behavioural reference
  int m_ph = 0, m_cnt = 0, m_lows = 0;
  bit m_ost = 1, m_drv = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_lows = 0; m_ost = 1; m_drv = 1;
    end else begin
      bit acc;
      m_lows = (pin_en && !pin_n) ? m_lows + 1 : 0;
      acc = (m_lows >= FL);
      if (por || wdt || wake || acc) begin
        m_ph = 0; m_cnt = 0; m_ost = por || wake; m_drv = por || acc;
      end else if (m_ph == 0) begin
        m_cnt = 0;
        if (!pwrt_n) m_ph = 1;
        else m_ph = (m_ost && mode < 3) ? 2 : 3;
      end else if (m_ph == 1) begin
        if (rc_tick) m_cnt++;
        if (m_cnt == PW) begin m_cnt = 0; m_ph = (m_ost && mode < 3) ? 2 : 3; end
      end else if (m_ph == 2) begin
        if (osc_tick) m_cnt++;
        if (m_cnt == OC) begin m_cnt = 0; m_ph = 3; end
      end
    end
    #1;
    if (rst_n) begin
      int e_ph; bit e_rst, e_drv;
      e_ph = m_ph; e_rst = (m_ph != 3); e_drv = e_rst && pin_en && m_drv;
      checks++;
      if (phase !== 2'(e_ph) || dev_rst !== e_rst || pin_drive !== e_drv) begin
        errors++;
        $display("FAIL %s: phase/rst/drive = %0d/%0b/%0b expected %0d/%0b/%0b",
                 cur_req, phase, dev_rst, pin_drive, e_ph, e_rst, e_drv);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    if (which == 0) por = 1'b1; else if (which == 1) wdt = 1'b1; else wake = 1'b1;
    @(negedge clk);
    por = 1'b0; wdt = 1'b0; wake = 1'b0;
  endtask

  task automatic pin_low(input int n);
    @(negedge clk); pin_n = 1'b0;
    cyc(n);
    pin_n = 1'b1;
  endtask

  task automatic wait_run(input string req);
    int n = 0;
    while (dev_rst && n < 400) begin @(negedge clk); n++; end
    chk(!dev_rst && phase == 2'd3, req, phase, 3);
  endtask

  initial begin
    cyc(3);
    chk(phase == 2'd0 && dev_rst, "R1", phase, 0);
    @(negedge clk); rst_n = 1'b1;
    #1 chk(phase == 2'd0 && dev_rst && pin_drive, "R1", dev_rst, 1);
    cur_req = "R6";
    wait_run("R7");

    cur_req = "R2";
    pin_low(FL - 1);
    cyc(2);
    chk(phase == 2'd3 && !dev_rst, "R2", phase, 3);
    pin_low(FL);
    #1 chk(dev_rst && pin_drive, "R2", pin_drive, 1);
    cur_req = "R9";
    wait_run("R9");

    cur_req = "R9";
    strobe(1);
    #1 chk(dev_rst && !pin_drive, "R9", pin_drive, 0);
    cur_req = "R7";
    wait_run("R7");

    mode = 3'd4;
    strobe(2);
    #1 chk(!pin_drive, "R9", pin_drive, 0);
    wait_run("R8");
    mode = 3'd2;
    strobe(2);
    wait_run("R7");

    cur_req = "R3";
    pin_en = 1'b0;
    pin_low(3 * FL);
    cyc(2);
    chk(phase == 2'd3 && !dev_rst, "R3", phase, 3);
    strobe(0);
    #1 chk(dev_rst && !pin_drive, "R3", pin_drive, 0);
    wait_run("R3");
    pin_en = 1'b1;

    cur_req = "R5";
    pwrt_n = 1'b1; mode = 3'd0;
    strobe(0);
    cyc(1);
    chk(phase == 2'd2, "R5", phase, 2);
    wait_run("R8");
    mode = 3'd5;
    strobe(0);
    cyc(1);
    chk(phase == 2'd3, "R8", phase, 3);

    cur_req = "R4";
    pwrt_n = 1'b0; mode = 3'd1;
    strobe(0);
    cyc(6);
    chk(phase == 2'd1, "R4", phase, 1);
    strobe(1);
    #1 chk(phase == 2'd0 && dev_rst, "R4", phase, 0);
    wait_run("R4");
    strobe(0);
    wait (phase == 2'd2);
    cyc(3);
    strobe(2);
    #1 chk(phase == 2'd0, "R4", phase, 0);
    wait_run("R7");
    pin_low(FL + 6);
    #1 chk(phase == 2'd0 && dev_rst, "R4", phase, 0);
    wait_run("R4");

    cyc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule